// File: doc/BRIEF.md
# Linked-List Packet Chain Walker

This block is a DMA engine that walks a chain of packets kept in memory. Each packet opens with one header word. The header's upper byte tells how many payload words come after it. Its lower 24 bits point to the next packet. The walker reads the header and pushes the payload words, in order, onto a valid/ready output stream that feeds a peripheral command port. It then follows the pointer. The walk ends at a terminating pointer, meaning any pointer with bit 23 set.

Two guards stop a runaway chain. The first is a loop detector with three remembered addresses: the last one visited, a lower one and a higher one. The second is a hard limit on how many packet headers are read. When the walker finishes, its pointer register shows the pointer it did not follow, busy drops, and a one-cycle interrupt fires. The abort input ends the walk at the next word boundary and does not raise the interrupt.

Top module: `dma_chain_walker`

## Requirements
- R1: A start pulse while idle with control value 0x01000401 sets busy in the next cycle. A start pulse while busy is ignored. A start pulse while idle with any other control value causes no memory read and leaves busy low. It also leaves the pointer register unchanged and pulses done_irq in the next cycle.
- R2: Every memory address, whether for a header or a payload word, is masked with 0x1FFFFC before use. This makes addresses word aligned within a 21-bit space, and the start pointer is masked the same way.
- R3: Header bits [31:24] give the payload length in words, and header bits [23:0] give the next pointer. The payload words are the words that follow the header, and they appear on the output stream in memory order.
- R4: An offered output word stays valid with unchanged data until out_ready accepts it.
- R5: A header whose length is zero forwards no payload words, and the walker moves straight to its next pointer.
- R6: The walk ends once a packet's payload is done and its next pointer has bit 23 set, whatever the other bits hold. At that point ptr_q holds that pointer, busy falls, and done_irq is high for exactly that one cycle.
- R7: Before each header read, the masked packet address is compared with the stored lower and higher addresses. All three stored addresses start at 0xFFFFFF. A match ends the walk with an interrupt, no read takes place, and ptr_q keeps the pointer that led there. When there is no match, the address is stored as lower if it is below the last address and as higher otherwise, and it then becomes the last address.
- R8: A walk ends with an interrupt, and without a read, when a packet is about to be visited after more than MAX_PKTS headers have already been read. In that case ptr_q holds that packet's pointer.
- R9: An abort while busy stops the walk after the word in flight has been accepted. ptr_q keeps the pending next pointer, busy clears, and done_irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| ctrl | input | 32 | Control value sampled with start |
| start_ptr | input | 24 | First packet pointer |
| abort | input | 1 | Stop request |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 21 | Byte address of the read |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| out_valid | output | 1 | Payload word offered |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Peripheral accepts the word |
| busy | output | 1 | Walk in progress |
| done_irq | output | 1 | One-cycle completion interrupt |
| ptr_q | output | 24 | Current or final next pointer |

## Verification
Busy rises one cycle after an accepted start. For a rejected control value, the interrupt appears in that same next cycle. When a walk finishes, the interrupt shares its one cycle with the first cycle in which busy reads low. The bench drives every input on the falling edge and samples outputs on that edge too, so each check reads the value that the preceding rising edge registered. Stream words are recorded at the falling edge on which valid and ready are both high, which comes just before the edge that transfers them.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;
  localparam logic [31:0] WALK_CTRL = 32'h0100_0401;
  localparam logic [23:0] SEEN_INIT = 24'hFF_FFFF;
  localparam logic [20:0] ADDR_MASK = 21'h1F_FFFC;

  typedef enum logic [2:0] {
    S_IDLE, S_VISIT, S_HDR, S_PRD, S_PWAIT, S_POUT, S_LINK
  } walk_st_e;

  function automatic logic [20:0] phys_addr(input logic [23:0] p);
    return p[20:0] & ADDR_MASK;
  endfunction

  function automatic logic [7:0] hdr_len(input logic [31:0] w);
    return w[31:24];
  endfunction

  function automatic logic [23:0] hdr_next(input logic [31:0] w);
    return w[23:0];
  endfunction

  function automatic logic is_term(input logic [23:0] p);
    return p[23];
  endfunction

  function automatic logic [20:0] step_addr(input logic [20:0] a);
    return (a + 21'd4) & ADDR_MASK;
  endfunction
endpackage

// File: rtl/walk_loop_guard.sv
module walk_loop_guard (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        probe_en,
  input  logic [23:0] probe_addr,
  output logic        hit
);
  import dma_walk_pkg::*;

  logic [23:0] last_q, lo_q, hi_q;

  assign hit = (probe_addr == lo_q) || (probe_addr == hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= SEEN_INIT;
      lo_q   <= SEEN_INIT;
      hi_q   <= SEEN_INIT;
    end else if (clear) begin
      last_q <= SEEN_INIT;
      lo_q   <= SEEN_INIT;
      hi_q   <= SEEN_INIT;
    end else if (probe_en && !hit) begin
      if (probe_addr < last_q) lo_q <= probe_addr;
      else                     hi_q <= probe_addr;
      last_q <= probe_addr;
    end
  end
endmodule

// File: rtl/walk_pkt_limiter.sv
module walk_pkt_limiter #(
  parameter int MAX_PKTS = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic over
);
  localparam int CNT_W = $clog2(MAX_PKTS + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_PKTS);

  logic [CNT_W-1:0] cnt_q;

  assign over = cnt_q > LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (bump)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int MAX_PKTS = 2_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] ctrl,
  input  logic [23:0] start_ptr,
  input  logic        abort,
  output logic        mem_rd,
  output logic [20:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready,
  output logic        busy,
  output logic        done_irq,
  output logic [23:0] ptr_q
);
  import dma_walk_pkg::*;

  walk_st_e    st_q;
  logic [20:0] cur_q;
  logic [7:0]  remain_q;
  logic        ov_q;
  logic [31:0] od_q;
  logic        abort_pend_q;
  logic        irq_q;
  logic [23:0] ptr_r;

  // named internal events
  logic        accept_ev, visit_ev, advance, loop_hit, limit_hit, stop_hit;
  logic [23:0] visit_addr;

  assign accept_ev  = (st_q == S_IDLE) && start && (ctrl == WALK_CTRL);
  assign visit_ev   = (st_q == S_VISIT);
  assign visit_addr = {3'b000, phys_addr(ptr_r)};
  assign stop_hit   = loop_hit || limit_hit;
  assign advance    = visit_ev && !stop_hit && !abort_pend_q;

  assign mem_rd   = advance || ((st_q == S_PRD) && !abort_pend_q);
  assign mem_addr = (st_q == S_PRD) ? cur_q : phys_addr(ptr_r);

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign busy      = (st_q != S_IDLE);
  assign done_irq  = irq_q;
  assign ptr_q     = ptr_r;

  walk_loop_guard u_guard (
    .clk(clk), .rst_n(rst_n), .clear(accept_ev),
    .probe_en(advance), .probe_addr(visit_addr), .hit(loop_hit)
  );

  walk_pkt_limiter #(.MAX_PKTS(MAX_PKTS)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(accept_ev),
    .bump(advance), .over(limit_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      cur_q        <= '0;
      remain_q     <= '0;
      ov_q         <= 1'b0;
      od_q         <= '0;
      abort_pend_q <= 1'b0;
      irq_q        <= 1'b0;
      ptr_r        <= '0;
    end else begin
      irq_q <= 1'b0;
      if (abort && st_q != S_IDLE) abort_pend_q <= 1'b1;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            if (ctrl == WALK_CTRL) begin
              st_q         <= S_VISIT;
              ptr_r        <= {3'b000, phys_addr(start_ptr)};
              abort_pend_q <= 1'b0;
            end else begin
              irq_q <= 1'b1;
            end
          end
        end
        S_VISIT: begin
          if (abort_pend_q) st_q <= S_IDLE;
          else if (stop_hit) begin
            st_q  <= S_IDLE;
            irq_q <= 1'b1;
          end else st_q <= S_HDR;
        end
        S_HDR: begin
          remain_q <= hdr_len(mem_rdata);
          ptr_r    <= hdr_next(mem_rdata);
          cur_q    <= step_addr(phys_addr(ptr_r));
          st_q     <= (hdr_len(mem_rdata) == 8'd0) ? S_LINK : S_PRD;
        end
        S_PRD: begin
          st_q <= abort_pend_q ? S_IDLE : S_PWAIT;
        end
        S_PWAIT: begin
          od_q <= mem_rdata;
          ov_q <= 1'b1;
          st_q <= S_POUT;
        end
        S_POUT: begin
          if (out_ready) begin
            ov_q     <= 1'b0;
            cur_q    <= step_addr(cur_q);
            remain_q <= remain_q - 8'd1;
            st_q     <= (remain_q == 8'd1) ? S_LINK : S_PRD;
          end
        end
        S_LINK: begin
          if (abort_pend_q) st_q <= S_IDLE;
          else if (is_term(ptr_r)) begin
            st_q  <= S_IDLE;
            irq_q <= 1'b1;
          end else st_q <= S_VISIT;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] ctrl,
  input logic        busy,
  input logic        done_irq,
  input logic        mem_rd,
  input logic [20:0] mem_addr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        visit_ev,
  input logic        stop_hit
);
  import dma_walk_pkg::*;

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ctrl == WALK_CTRL) |=> busy);

  p_bad_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ctrl != WALK_CTRL) |=> (done_irq && !busy));

  p_word_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[1:0] == 2'b00));

  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_stop_noread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_ev && stop_hit) |-> !mem_rd);
endmodule

bind dma_chain_walker dma_chain_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .busy(busy),
  .done_irq(done_irq), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .visit_ev(visit_ev), .stop_hit(stop_hit)
);

// File: tb/dma_chain_walker_tb_top.sv
module dma_chain_walker_tb_top;
  localparam int TB_MAX = 3;
  localparam logic [31:0] WALK = 32'h0100_0401;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrl = '0;
  logic [23:0] start_ptr = '0;
  logic        abort = 1'b0;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        busy, done_irq;
  logic [23:0] ptr_q;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [31:0] mem [256];
  logic [31:0] got [32];
  int n_got;
  logic irq_end, irq_any;

  always #4 clk = ~clk;

  dma_chain_walker #(.MAX_PKTS(TB_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .start_ptr(start_ptr),
    .abort(abort), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .done_irq(done_irq), .ptr_q(ptr_q)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[9:2]];
      rd_count  <= rd_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mem_clear();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic put(input logic [11:0] a, input logic [31:0] d);
    mem[a[9:2]] = d;
  endtask

  // rmode 0: ready always high, 1: toggling, 2: held low until abort is issued
  task automatic run_walk(input logic [23:0] sp, input int rmode, input bit poke, input bit do_abort);
    logic hold;
    logic [31:0] hold_d;
    int abort_step;
    hold = 0; hold_d = '0; n_got = 0; irq_end = 0; irq_any = 0; abort_step = -1;
    start = 1; ctrl = WALK; start_ptr = sp;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R1 busy after start", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 3000; i++) begin
      if (hold) chk(out_valid && out_data == hold_d, "R4 word held", out_data, hold_d);
      if (done_irq) irq_any = 1;
      if (!busy) begin irq_end = done_irq; break; end
      abort = 0;
      start = 0;
      case (rmode)
        0: out_ready = 1;
        1: out_ready = i[0];
        default: begin
          if (out_valid && abort_step < 0) begin abort = 1; abort_step = i; out_ready = 0; end
          else out_ready = (abort_step >= 0);
        end
      endcase
      if (poke && i == 4) begin start = 1; start_ptr = 24'h000300; end
      if (out_valid && out_ready && n_got < 32) begin got[n_got] = out_data; n_got++; end
      hold = out_valid && !out_ready;
      hold_d = out_data;
      @(negedge clk);
    end
    abort = 0; start = 0; out_ready = 1;
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done_irq === 1'b0, "R1 reset idle", {30'd0, busy, done_irq}, 32'd0);
    chk(out_valid === 1'b0 && mem_rd === 1'b0, "R4 reset no output", {30'd0, out_valid, mem_rd}, 32'd0);
    chk(ptr_q === 24'd0, "R6 reset pointer", {8'd0, ptr_q}, 32'd0);
  endtask

  // R3/R5/R6/R2/R1: masked start, zero-length packet, terminator, restart ignored
  task automatic t_chain();
    mem_clear();
    put(12'h040, 32'h02_600080);
    put(12'h044, 32'h0000_0011);
    put(12'h048, 32'h0000_0022);
    put(12'h080, 32'h00_0000C0);
    put(12'h084, 32'hDEAD_BEEF);
    put(12'h0C0, 32'h01_812345);
    put(12'h0C4, 32'h0000_0033);
    run_walk(24'hE00040, 1, 1, 0);
    chk(n_got == 3, "R5 word count", n_got, 3);
    chk(got[0] == 32'h11 && got[1] == 32'h22, "R3 payload order", got[1], 32'h22);
    chk(got[2] == 32'h33, "R2 masked next pointer followed", got[2], 32'h33);
    chk(ptr_q == 24'h812345, "R6 final pointer", {8'd0, ptr_q}, 32'h812345);
    chk(irq_end == 1'b1, "R6 irq with busy fall", {31'd0, irq_end}, 32'd1);
    @(negedge clk);
    chk(done_irq == 1'b0, "R6 irq one cycle", {31'd0, done_irq}, 32'd0);
  endtask

  task automatic t_loop();
    mem_clear();
    put(12'h100, 32'h01_000200);
    put(12'h104, 32'h0000_AAA1);
    put(12'h200, 32'h01_000100);
    put(12'h204, 32'h0000_AAA2);
    run_walk(24'h000100, 0, 0, 0);
    chk(n_got == 2 && got[0] == 32'hAAA1 && got[1] == 32'hAAA2, "R7 loop words", n_got, 2);
    chk(ptr_q == 24'h000100, "R7 loop pointer", {8'd0, ptr_q}, 32'h100);
    chk(irq_end == 1'b1, "R7 loop irq", {31'd0, irq_end}, 32'd1);
  endtask

  task automatic t_limit();
    mem_clear();
    for (int k = 0; k < 6; k++) begin
      put(12'h200 + 12'(k * 16), {8'h01, 24'h000210 + 24'(k * 16)});
      put(12'h204 + 12'(k * 16), 32'h5000 + 32'(k));
    end
    run_walk(24'h000200, 0, 0, 0);
    chk(n_got == TB_MAX + 1, "R8 packets before limit", n_got, TB_MAX + 1);
    chk(got[TB_MAX] == 32'h5000 + TB_MAX, "R8 last word", got[TB_MAX], 32'h5000 + TB_MAX);
    chk(ptr_q == 24'h000240, "R8 limit pointer", {8'd0, ptr_q}, 32'h240);
    chk(irq_end == 1'b1, "R8 limit irq", {31'd0, irq_end}, 32'd1);
  endtask

  task automatic t_abort();
    mem_clear();
    put(12'h100, 32'h03_000200);
    put(12'h104, 32'h0000_0B01);
    put(12'h108, 32'h0000_0B02);
    put(12'h10C, 32'h0000_0B03);
    put(12'h200, 32'h01_800000);
    run_walk(24'h000100, 2, 0, 1);
    chk(n_got == 1 && got[0] == 32'h0B01, "R9 one word after abort", n_got, 1);
    chk(ptr_q == 24'h000200, "R9 pending pointer", {8'd0, ptr_q}, 32'h200);
    chk(irq_any == 1'b0, "R9 no irq", {31'd0, irq_any}, 32'd0);
  endtask

  task automatic t_bad_ctrl();
    int rd0;
    logic [23:0] p0;
    rd0 = rd_count; p0 = ptr_q;
    start = 1; ctrl = 32'h0100_0201; start_ptr = 24'h000040;
    @(negedge clk);
    start = 0;
    chk(done_irq == 1'b1 && busy == 1'b0, "R1 bad ctrl irq", {30'd0, done_irq, busy}, 32'd2);
    @(negedge clk);
    chk(done_irq == 1'b0, "R1 bad ctrl irq one cycle", {31'd0, done_irq}, 32'd0);
    chk(rd_count == rd0 && ptr_q == p0, "R1 bad ctrl no read", rd_count, rd0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_chain();
    t_loop();
    t_limit();
    t_abort();
    t_bad_ctrl();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule